// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits in front of one memory segment's page-write logic. It watches every latched byte write to the segment, given as a segment-local address and a data byte. It decides whether the write goes on to the array or is held back. Protection is switched on and off only by short keyed command sequences of exact address/data pairs. So a stray write from a crashed host cannot alter stored data once the segment is locked.

A three-write prefix (0xAA at local 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555) locks the segment. It also opens a load window, in which the sector bytes that follow are accepted. The page-write logic closes that window with a pulse when its load period ends. A six-write sequence (0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555) unlocks the segment. One instance is placed per segment, and each one must be sent its own sequence.

Accepted writes leave the block one clock after they arrive, on a registered array-write strobe with its address and data. A synchronous clear input returns the segment to the unprotected state, as a part leaves the factory.

Top module: `swp_cmd_detect`

## Requirements
- R1: After reset, prot_on is 0, wr_permit is 1 and arr_we is 0.
- R2: While unprotected, a write that is not a matched command step appears on arr_we, arr_addr and arr_data one clock after it is presented, with the same address and data, and arr_we never rises without a write in the previous cycle.
- R3: The three writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 set prot_on to 1 one clock after the last of them, and open the load window (wr_permit = 1), so the data writes that follow are stored.
- R4: A window_end pulse closes the window from the next clock on. While prot_on is 1 and the window is closed, wr_permit is 0 and every write is dropped (arr_we stays 0).
- R5: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear prot_on one clock after the last of them.
- R6: A write that matches the expected next command step is never passed to the array.
- R7: A write that does not match the expected step of a sequence in progress returns the matcher to idle and leaves prot_on unchanged. That write is then handled as an ordinary data write: stored if permitted, dropped otherwise.
- R8: While the load window is open, every write, including one that looks like a command byte, is stored as data and starts no sequence.
- R9: prot_clr clears prot_on, closes the window and resets the matcher at the next clock. A write presented in the same cycle is not stored, and a sequence in progress before the clear does not complete after it.
- R10: The enable prefix given while already protected keeps prot_on at 1 and reopens the load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_clr | input | 1 | Synchronous clear to the unprotected state |
| wr_valid | input | 1 | A latched byte write is presented this cycle |
| wr_addr | input | ADDR_W (15) | Segment-local write address |
| wr_data | input | DATA_W (8) | Write data byte |
| window_end | input | 1 | Pulse from page-write logic: the load window has ended |
| arr_we | output | 1 | Registered write strobe to the array |
| arr_addr | output | ADDR_W (15) | Address of the accepted write |
| arr_data | output | DATA_W (8) | Data of the accepted write |
| wr_permit | output | 1 | Writes are currently accepted (unprotected or window open) |
| prot_on | output | 1 | Segment protection state |

## Verification
A matcher left in a mid-sequence state shows up on the very next write. A command byte is swallowed when it should have been stored, or a data byte starts a sequence it should not. Either way arr_we differs from the expected value one clock later. A wrong protection bit or window flag shows at once on prot_on and wr_permit, and on the next write as a stored or dropped byte. The scoreboard therefore compares every write's outcome one cycle after it, and checks the flags after each completed or broken sequence.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // Matcher progress through the keyed sequences.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,  // first key byte seen
    ST_K2   = 3'd2,  // second key byte seen
    ST_D3   = 3'd3,  // unlock path: 0x80 seen
    ST_D4   = 3'd4,  // unlock path: repeated first key seen
    ST_D5   = 3'd5   // unlock path: repeated second key seen
  } seq_st_e;

  // What the current write turned out to be.
  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_DATA = 3'd1,
    ACT_STEP = 3'd2,
    ACT_ON   = 3'd3,
    ACT_OFF  = 3'd4
  } seq_act_e;

  // Key indices into the decoded hit vector.
  localparam int unsigned K_FIRST  = 0;  // 0xAA at address A
  localparam int unsigned K_SECOND = 1;  // 0x55 at address B
  localparam int unsigned K_LOCK   = 2;  // 0xA0 at address A
  localparam int unsigned K_UNPFX  = 3;  // 0x80 at address A
  localparam int unsigned K_UNLOCK = 4;  // 0x20 at address A
  localparam int unsigned N_KEYS   = 5;

endpackage

// File: rtl/swp_key_decode.sv
module swp_key_decode #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 'h2AAA,
  parameter logic [DATA_W-1:0] CODE_FIRST  = 'hAA,
  parameter logic [DATA_W-1:0] CODE_SECOND = 'h55,
  parameter logic [DATA_W-1:0] CODE_LOCK   = 'hA0,
  parameter logic [DATA_W-1:0] CODE_UNPFX  = 'h80,
  parameter logic [DATA_W-1:0] CODE_UNLOCK = 'h20
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           data,
  output logic [swp_pkg::N_KEYS-1:0]  hits
);
  import swp_pkg::*;

  function automatic logic [ADDR_W-1:0] key_addr(input int unsigned idx);
    return (idx == K_SECOND) ? ADDR_B : ADDR_A;
  endfunction

  function automatic logic [DATA_W-1:0] key_data(input int unsigned idx);
    case (idx)
      K_FIRST:  return CODE_FIRST;
      K_SECOND: return CODE_SECOND;
      K_LOCK:   return CODE_LOCK;
      K_UNPFX:  return CODE_UNPFX;
      default:  return CODE_UNLOCK;
    endcase
  endfunction

  function automatic logic key_match(input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d,
                                     input logic [ADDR_W-1:0] ka,
                                     input logic [DATA_W-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  for (genvar i = 0; i < N_KEYS; i++) begin : g_key
    assign hits[i] = key_match(addr, data, key_addr(i), key_data(i));
  end

endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_valid,
  input  logic                       win_open,
  input  logic [swp_pkg::N_KEYS-1:0] hits,
  output swp_pkg::seq_act_e          act,
  output logic                       in_seq
);
  import swp_pkg::*;

  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    act  = ACT_NONE;
    if (wr_valid && win_open) begin
      act  = ACT_DATA;
      st_d = ST_IDLE;
    end else if (wr_valid) begin
      act  = ACT_DATA;
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (hits[K_FIRST])  begin act = ACT_STEP; st_d = ST_K1; end
        ST_K1:   if (hits[K_SECOND]) begin act = ACT_STEP; st_d = ST_K2; end
        ST_K2: begin
          if (hits[K_LOCK])       begin act = ACT_ON;   st_d = ST_IDLE; end
          else if (hits[K_UNPFX]) begin act = ACT_STEP; st_d = ST_D3;   end
        end
        ST_D3:   if (hits[K_FIRST])  begin act = ACT_STEP; st_d = ST_D4; end
        ST_D4:   if (hits[K_SECOND]) begin act = ACT_STEP; st_d = ST_D5; end
        ST_D5:   if (hits[K_UNLOCK]) begin act = ACT_OFF;  st_d = ST_IDLE; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 st_q <= ST_IDLE;
    else if (clr || win_open)   st_q <= ST_IDLE;
    else                        st_q <= st_d;
  end

  assign in_seq = (st_q != ST_IDLE);

endmodule

// File: rtl/swp_prot_reg.sv
module swp_prot_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_on,
  input  logic set_off,
  input  logic win_close,
  output logic prot_q,
  output logic win_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      win_q  <= 1'b0;
    end else if (clr) begin
      prot_q <= 1'b0;
      win_q  <= 1'b0;
    end else if (set_on) begin
      prot_q <= 1'b1;
      win_q  <= 1'b1;
    end else begin
      if (set_off)   prot_q <= 1'b0;
      if (win_close) win_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/swp_wr_gate.sv
module swp_wr_gate #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_data,
  input  logic              permit,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);

  logic store;
  assign store = is_data && permit && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we   <= 1'b0;
      arr_addr <= '0;
      arr_data <= '0;
    end else begin
      arr_we <= store;
      if (store) begin
        arr_addr <= addr;
        arr_data <= data;
      end
    end
  end

endmodule

// File: rtl/swp_cmd_detect.sv
module swp_cmd_detect #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              window_end,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              wr_permit,
  output logic              prot_on
);
  import swp_pkg::*;

  logic [N_KEYS-1:0] key_hits;
  seq_act_e          seq_act;
  logic              in_seq;
  logic              win_q;

  // Named events for the checker.
  logic evt_step, evt_on, evt_off, evt_data, evt_abort, evt_cmd;

  swp_key_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_dec (
    .addr (wr_addr),
    .data (wr_data),
    .hits (key_hits)
  );

  swp_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (prot_clr),
    .wr_valid (wr_valid),
    .win_open (win_q),
    .hits     (key_hits),
    .act      (seq_act),
    .in_seq   (in_seq)
  );

  assign evt_step  = (seq_act == ACT_STEP);
  assign evt_on    = (seq_act == ACT_ON);
  assign evt_off   = (seq_act == ACT_OFF);
  assign evt_data  = (seq_act == ACT_DATA);
  assign evt_abort = evt_data && in_seq;
  assign evt_cmd   = evt_step || evt_on || evt_off;

  swp_prot_reg u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (prot_clr),
    .set_on    (evt_on),
    .set_off   (evt_off),
    .win_close (window_end),
    .prot_q    (prot_on),
    .win_q     (win_q)
  );

  assign wr_permit = !prot_on || win_q;

  swp_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_data  (evt_data),
    .permit   (wr_permit),
    .clr      (prot_clr),
    .addr     (wr_addr),
    .data     (wr_data),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .arr_data (arr_data)
  );

endmodule

// File: rtl/swp_cmd_detect_chk.sv
module swp_cmd_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic prot_clr,
  input logic wr_valid,
  input logic arr_we,
  input logic wr_permit,
  input logic prot_on,
  input logic evt_cmd,
  input logic evt_on,
  input logic evt_off,
  input logic evt_abort
);

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !prot_on && wr_permit && !arr_we); // R1
  AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) arr_we |-> $past(wr_valid)); // R2
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n) wr_valid && !prot_on && !evt_cmd && !prot_clr |=> arr_we); // R2
  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n) evt_on && !prot_clr |=> prot_on && wr_permit); // R3
  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n) wr_valid && !wr_permit |=> !arr_we); // R4
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) evt_off && !prot_clr |=> !prot_on); // R5
  AST_CMD_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n) evt_cmd |=> !arr_we); // R6
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) evt_abort && !prot_clr |=> $stable(prot_on)); // R7
  AST_PROT_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(prot_on) |-> $past(evt_on || evt_off || prot_clr)); // R7
  AST_WINDOW_STORES: assert property (@(posedge clk) disable iff (!rst_n) wr_valid && prot_on && wr_permit && !prot_clr |=> arr_we); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) prot_clr |=> !prot_on && wr_permit && !arr_we); // R9

endmodule

bind swp_cmd_detect swp_cmd_detect_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prot_clr  (prot_clr),
  .wr_valid  (wr_valid),
  .arr_we    (arr_we),
  .wr_permit (wr_permit),
  .prot_on   (prot_on),
  .evt_cmd   (evt_cmd),
  .evt_on    (evt_on),
  .evt_off   (evt_off),
  .evt_abort (evt_abort)
);

// File: tb/tb_swp_cmd_detect.sv
module tb_swp_cmd_detect;

  localparam logic [14:0] A = 15'h5555;
  localparam logic [14:0] B = 15'h2AAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_clr = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        window_end = 1'b0;
  logic        arr_we;
  logic [14:0] arr_addr;
  logic [7:0]  arr_data;
  logic        wr_permit;
  logic        prot_on;

  swp_cmd_detect dut (
    .clk(clk), .rst_n(rst_n), .prot_clr(prot_clr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .window_end(window_end),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .wr_permit(wr_permit), .prot_on(prot_on)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Scoreboard of expected array writes: {addr, data}.
  logic [22:0] exp_q[$];

  // Bench model: protection, window, and how far into a sequence the host is.
  bit m_prot = 0;
  bit m_win  = 0;
  int m_pos  = 0;   // 0 idle, 1..2 shared prefix, 3..5 unlock tail

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the array is written.
  always @(negedge clk) begin
    if (rst_n && arr_we && !done) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6: actual unexpected write %0h=%0h expected none", arr_addr, arr_data);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        if ({arr_addr, arr_data} !== e) begin
          n_fail++;
          $display("FAIL R2: actual %0h expected %0h", {arr_addr, arr_data}, e);
        end
      end
    end
  end

  // Driver: works out the expected outcome, pushes it, drives one write.
  task automatic wr(input string tag, input logic [14:0] a, input logic [7:0] d, input bit clr = 0);
    bit cmd = 0;
    bit store;
    if (!m_win && !clr) begin
      if ((m_pos == 0 || m_pos == 3) && a == A && d == 8'hAA) begin cmd = 1; m_pos = m_pos + 1; end
      else if ((m_pos == 1 || m_pos == 4) && a == B && d == 8'h55) begin cmd = 1; m_pos = m_pos + 1; end
      else if (m_pos == 2 && a == A && d == 8'hA0) begin cmd = 1; m_pos = 0; m_prot = 1; m_win = 1; end
      else if (m_pos == 2 && a == A && d == 8'h80) begin cmd = 1; m_pos = 3; end
      else if (m_pos == 5 && a == A && d == 8'h20) begin cmd = 1; m_pos = 0; m_prot = 0; end
    end
    store = !cmd && !clr && (!m_prot || m_win || cmd);
    if (!cmd) m_pos = 0;
    if (clr) begin m_prot = 0; m_win = 0; m_pos = 0; end
    if (store) exp_q.push_back({a, d});
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d; prot_clr = clr;
    @(negedge clk);
    wr_valid = 0; prot_clr = 0;
    chk(tag, {31'd0, arr_we}, {31'd0, store});
  endtask

  task automatic end_window();
    @(negedge clk);
    window_end = 1;
    @(negedge clk);
    window_end = 0;
    m_win = 0;
  endtask

  task automatic lock(input string tag);
    wr(tag, A, 8'hAA); wr(tag, B, 8'h55); wr(tag, A, 8'hA0);
  endtask

  task automatic unlock(input string tag);
    wr(tag, A, 8'hAA); wr(tag, B, 8'h55); wr(tag, A, 8'h80);
    wr(tag, A, 8'hAA); wr(tag, B, 8'h55); wr(tag, A, 8'h20);
  endtask

  task automatic flags(input string tag);
    chk(tag, {31'd0, prot_on}, {31'd0, m_prot});
    chk(tag, {31'd0, wr_permit}, {31'd0, (!m_prot || m_win)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 prot", {31'd0, prot_on}, 32'd0);
    chk("R1 permit", {31'd0, wr_permit}, 32'd1);
    chk("R1 we", {31'd0, arr_we}, 32'd0);

    // R2: unprotected pass-through
    wr("R2", 15'h0100, 8'h11);
    wr("R2", 15'h7FFF, 8'hFE);
    wr("R2", A, 8'h00);

    // R3 / R6: lock opens a window; prefix bytes not stored
    lock("R6 lock prefix");
    flags("R3");
    wr("R3 window", 15'h0200, 8'h21);
    wr("R3 window", 15'h0201, 8'h22);
    // R8: key-looking bytes inside the window are data
    wr("R8", A, 8'hAA);
    wr("R8", B, 8'h55);
    wr("R8", A, 8'hA0);
    flags("R8");

    // R4: window closed, locked writes dropped
    end_window();
    flags("R4");
    wr("R4", 15'h0300, 8'h33);
    wr("R4", A, 8'h77);

    // R7: broken lock prefix while protected
    wr("R7", A, 8'hAA); wr("R7", B, 8'h55); wr("R7", A, 8'h33);
    flags("R7");
    // R7: broken unlock tail
    wr("R7", A, 8'hAA); wr("R7", B, 8'h55); wr("R7", A, 8'h80);
    wr("R7", A, 8'hAA); wr("R7", B, 8'h55); wr("R7", A, 8'h21);
    flags("R7 tail");

    // R10: relock while protected reopens the window
    lock("R10");
    flags("R10");
    wr("R10", 15'h0400, 8'h44);
    end_window();
    flags("R10 closed");

    // R5: unlock
    unlock("R5 R6");
    flags("R5");
    wr("R5", 15'h0500, 8'h55);

    // R7: broken prefix while unprotected stores the breaking byte
    wr("R7", A, 8'hAA); wr("R7", 15'h1234, 8'h44);
    flags("R7 open");

    // R9: clear with a write in the same cycle, after locking
    lock("R9");
    end_window();
    wr("R9", 15'h0600, 8'h66, 1);
    flags("R9");
    // R9: sequence in progress does not survive a clear
    wr("R9", A, 8'hAA); wr("R9", B, 8'h55);
    wr("R9", 15'h0000, 8'h00, 1);
    wr("R9", A, 8'hA0);
    flags("R9 after");

    repeat (3) @(negedge clk);
    chk("R6 scoreboard empty", exp_q.size(), 32'd0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule